// File: doc/BRIEF.md
# Stereo Soft Volume Stage with Idle Detection

This block scales a pair of 24-bit signed audio samples by a volume set from an 8-bit attenuation code per channel. Volume changes and muting never happen as a step. A gain register per output moves by one small increment per sample until it reaches the level the current controls ask for. A full swing from unity gain to silence therefore takes 1024 sample periods.

A mono mode sends one chosen input to both outputs. A common-volume mode applies the left code to both channels.

Each output path also watches the sample routed to it for a sustained idle pattern. An idle pattern is all-zero or all-one upper bits with a constant low nibble. When detection is enabled and such a run has lasted long enough, the path raises its zero flag and its output is held at zero.

Top module: `soft_atten`

## Requirements
- R1: After reset, out_l, out_r and out_vld are 0, all zero flags are 0, and both gain registers are at unity (1024/1024).
- R2: The target gain, in units of 1/1024, is 1024 for code 0x00 and (255 − code)·4 for codes 0x01 to 0xFF. Code 0xFF therefore targets silence.
- R3: On every sample strobe each gain register moves exactly one unit toward its target and stops when it reaches it. A change from unity to silence takes 1024 strobes.
- R4: When mute is high, the target of both channels is 0, whatever the codes are. When mute is released, the gain ramps back toward the coded target.
- R5: When indiv is 0, the right channel's target comes from code_l and code_r has no effect. When indiv is 1, the right channel uses code_r.
- R6: On a strobe, each output register loads floor((s·g + 512)/1024), saturated to the 24-bit signed range. Here s is the routed sample and g is the gain before that strobe's step. out_vld is high for exactly the cycle after a strobe, and the outputs hold their value between strobes.
- R7: With mono high, both outputs take in_l when mono_left is 1 and in_r when mono_left is 0. Each output still uses its own gain register.
- R8: A routed sample counts as idle when bits 23:4 are all 0 or all 1 and bits 3:0 equal those of the previous strobed sample on that path. The reset value of the previous nibble is 0. Any strobe that is not idle clears that path's run counter.
- R9: A path's zero flag is high when zd_en is high and its run counter has reached 8192 idle strobes. The flag follows zd_en in the same cycle, and the counter keeps running while zd_en is low.
- R10: While a path's zero flag is high, a strobe loads 0 into that output, and its gain still steps. zero_both is high exactly when both zero flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per stereo frame |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| code_l | input | 8 | Left attenuation code |
| code_r | input | 8 | Right attenuation code |
| indiv | input | 1 | 1: separate codes, 0: code_l for both channels |
| mute | input | 1 | Ramp both channels to silence |
| mono | input | 1 | Route one input to both outputs |
| mono_left | input | 1 | Mono source: 1 left, 0 right |
| zd_en | input | 1 | Idle detection enable |
| out_l | output | 24 | Left scaled sample, signed |
| out_r | output | 24 | Right scaled sample, signed |
| out_vld | output | 1 | Output strobe, one cycle after smp_vld |
| zero_l | output | 1 | Left path idle flag |
| zero_r | output | 1 | Right path idle flag |
| zero_both | output | 1 | Both paths idle |

## Verification
The gain ramp and idle forcing can act on the same strobe. The first silences an output gradually, and the second clears it at once while the gain underneath keeps stepping. The bench provokes this overlap by raising both zero flags with a long DC run and then asserting mute for several hundred strobes while the flags stay high. It then breaks the left run with a changed low nibble. The outputs are judged against a reference that tracks gain and run length from the requirements: they must be zero while forced, and the left output must resume at the gain reached by then, not at the gain held when forcing began.

// File: rtl/soft_atten.sv
module soft_atten #(
  parameter int DW      = 24,
  parameter int CW      = 8,
  parameter int RAMP    = 1024,
  parameter int ZFRAMES = 8192,
  parameter int ZLSB    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  input  logic [CW-1:0] code_l,
  input  logic [CW-1:0] code_r,
  input  logic          indiv,
  input  logic          mute,
  input  logic          mono,
  input  logic          mono_left,
  input  logic          zd_en,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          out_vld,
  output logic          zero_l,
  output logic          zero_r,
  output logic          zero_both
);
  localparam int SH  = $clog2(RAMP);
  localparam int GW  = SH + 1;
  localparam int PW  = DW + GW + 1;
  localparam int ZCW = $clog2(ZFRAMES + 1);
  localparam logic signed [PW-1:0] PMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic [GW-1:0] gain_of(input logic [CW-1:0] c);
    int t;
    if (c == '0) return GW'(RAMP);
    t = (((2 ** CW) - 1 - int'(c)) * RAMP) >> CW;
    return GW'(t);
  endfunction

  logic [DW-1:0] mono_src;
  logic [DW-1:0] src  [2];
  logic [GW-1:0] tgt  [2];
  logic [GW-1:0] gain [2];
  logic [DW-1:0] q    [2];
  logic [1:0]    zf;

  assign mono_src = mono_left ? in_l : in_r;
  assign src[0]   = mono ? mono_src : in_l;
  assign src[1]   = mono ? mono_src : in_r;
  assign tgt[0]   = mute ? '0 : gain_of(code_l);
  assign tgt[1]   = mute ? '0 : gain_of(indiv ? code_r : code_l);

  for (genvar ch = 0; ch < 2; ch++) begin : g_path
    logic [GW-1:0]          g;
    logic [ZCW-1:0]         cnt;
    logic [ZLSB-1:0]        lo;
    logic [DW-1:0]          y;
    logic signed [PW-1:0]   prod, shf;
    logic [DW-1:0]          res;
    logic                   idle;

    assign prod = PW'($signed(src[ch])) * PW'($signed({1'b0, g})) + PW'(RAMP / 2);
    assign shf  = prod >>> SH;
    assign res  = (shf > PMAX) ? PMAX[DW-1:0] : (shf < PMIN) ? PMIN[DW-1:0] : shf[DW-1:0];
    assign idle = ((&src[ch][DW-1:ZLSB]) || !(|src[ch][DW-1:ZLSB]))
                  && (src[ch][ZLSB-1:0] == lo);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        g   <= GW'(RAMP);
        cnt <= '0;
        lo  <= '0;
        y   <= '0;
      end else if (smp_vld) begin
        if (g < tgt[ch])      g <= g + 1'b1;
        else if (g > tgt[ch]) g <= g - 1'b1;
        y   <= zf[ch] ? '0 : res;
        lo  <= src[ch][ZLSB-1:0];
        cnt <= !idle ? '0 : (cnt == ZCW'(ZFRAMES)) ? cnt : cnt + 1'b1;
      end
    end

    assign zf[ch]   = zd_en && (cnt == ZCW'(ZFRAMES));
    assign gain[ch] = g;
    assign q[ch]    = y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= smp_vld;
  end

  assign out_l     = q[0];
  assign out_r     = q[1];
  assign zero_l    = zf[0];
  assign zero_r    = zf[1];
  assign zero_both = &zf;
endmodule

// File: rtl/soft_atten_chk.sv
module soft_atten_chk #(
  parameter int DW   = 24,
  parameter int GW   = 11,
  parameter int RAMP = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          mute,
  input logic          zd_en,
  input logic [GW-1:0] g0,
  input logic [GW-1:0] g1,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r,
  input logic          out_vld,
  input logic          zero_l,
  input logic          zero_r,
  input logic          zero_both
);
  assert_gain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(g0) - int'($past(g0)) <= 1) && (int'($past(g0)) - int'(g0) <= 1)
    && (int'(g1) - int'($past(g1)) <= 1) && (int'($past(g1)) - int'(g1) <= 1));

  assert_gain_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(g0) <= RAMP) && (int'(g1) <= RAMP));

  assert_gain_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(g0) && $stable(g1));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(out_l) && $stable(out_r) && !out_vld);

  assert_out_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);

  assert_mute_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && mute && (g0 == '0) && (g1 == '0) |=> (out_l == '0) && (out_r == '0));

  assert_zero_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && zero_l |=> out_l == '0);

  assert_zero_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !zd_en |-> !zero_l && !zero_r && !zero_both);

  assert_zero_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_both |-> zero_l && zero_r);
endmodule

bind soft_atten soft_atten_chk #(.DW(DW), .GW(GW), .RAMP(RAMP)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mute(mute), .zd_en(zd_en),
  .g0(gain[0]), .g1(gain[1]), .out_l(out_l), .out_r(out_r), .out_vld(out_vld),
  .zero_l(zero_l), .zero_r(zero_r), .zero_both(zero_both));

// File: tb/soft_atten_tb.sv
module soft_atten_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [23:0] in_l = '0, in_r = '0;
  logic [7:0] code_l = '0, code_r = '0;
  logic indiv = 0, mute = 0, mono = 0, mono_left = 0, zd_en = 0;
  logic [23:0] out_l, out_r;
  logic out_vld, zero_l, zero_r, zero_both;

  int nchk = 0, nfail = 0;
  int gm[2] = '{1024, 1024};
  int zc[2] = '{0, 0};
  logic [3:0] zlo[2] = '{4'h0, 4'h0};

  always #4 clk = ~clk;

  soft_atten dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .in_l(in_l), .in_r(in_r),
    .code_l(code_l), .code_r(code_r), .indiv(indiv), .mute(mute), .mono(mono),
    .mono_left(mono_left), .zd_en(zd_en), .out_l(out_l), .out_r(out_r),
    .out_vld(out_vld), .zero_l(zero_l), .zero_r(zero_r), .zero_both(zero_both));

  // {in_l, in_r, code_l, code_r, {indiv,mute,mono,mono_left}, strobes}
  localparam logic [79:0] VEC [9] = '{
    {24'h123456, 24'hEDCBA9, 8'h00, 8'h00, 4'b0000, 12'd4},
    {24'h400000, 24'hC00000, 8'h40, 8'h10, 4'b0000, 12'd1100},
    {24'h3FFFFF, 24'h800000, 8'h01, 8'hFE, 4'b1000, 12'd1100},
    {24'h200000, 24'h100000, 8'h01, 8'hFE, 4'b1100, 12'd1100},
    {24'h7FFFFF, 24'h800000, 8'h00, 8'h00, 4'b0000, 12'd1100},
    {24'h111111, 24'h222222, 8'h00, 8'h00, 4'b0011, 12'd3},
    {24'h111111, 24'h222222, 8'h00, 8'h00, 4'b0010, 12'd3},
    {24'h123456, 24'h654321, 8'hFF, 8'h00, 4'b1000, 12'd1100},
    {24'h123456, 24'h654321, 8'h00, 8'h00, 4'b0000, 12'd1100}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R6";
      1: return "R5";
      2, 7: return "R2";
      3: return "R4";
      4, 8: return "R3";
      default: return "R7";
    endcase
  endfunction

  function automatic int target(logic [7:0] c);
    if (mute) return 0;
    if (c == 8'h00) return 1024;
    return (255 - int'(c)) * 4;
  endfunction

  function automatic logic [23:0] rnd(logic [23:0] s, int g);
    longint p;
    p = (longint'($signed(s)) * g + 512) >>> 10;
    if (p > 64'sd8388607) p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[23:0];
  endfunction

  function automatic bit is_idle(logic [23:0] s, logic [3:0] prev);
    return ((s[23:4] == '0) || (&s[23:4])) && (s[3:0] == prev);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [23:0] l, logic [23:0] r, string tag);
    logic [23:0] s[2];
    logic [23:0] e[2];
    int t[2];
    s[0] = mono ? (mono_left ? l : r) : l;
    s[1] = mono ? (mono_left ? l : r) : r;
    t[0] = target(code_l);
    t[1] = target(indiv ? code_r : code_l);
    for (int c = 0; c < 2; c++) begin
      e[c] = (zd_en && zc[c] == 8192) ? 24'h0 : rnd(s[c], gm[c]);
      if (gm[c] < t[c]) gm[c]++;
      else if (gm[c] > t[c]) gm[c]--;
      if (is_idle(s[c], zlo[c])) begin
        if (zc[c] < 8192) zc[c]++;
      end else zc[c] = 0;
      zlo[c] = s[c][3:0];
    end
    @(negedge clk);
    in_l = l; in_r = r; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check(tag, "out_l", {8'h0, out_l}, {8'h0, e[0]});
    check(tag, "out_r", {8'h0, out_r}, {8'h0, e[1]});
    check(tag, "out_vld", {31'h0, out_vld}, 32'h1);
    check(tag, "zero flags", {29'h0, zero_l, zero_r, zero_both},
          {29'h0, zd_en && zc[0] == 8192, zd_en && zc[1] == 8192,
           zd_en && zc[0] == 8192 && zc[1] == 8192});
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog expired before end of test");
    finish_run();
  end

  initial begin
    logic [23:0] hl, hr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then unity gain on the first strobe
    check("R1", "reset outputs", {out_l, out_vld, zero_l, zero_r, zero_both}, 28'h0);
    check("R1", "reset out_r", {8'h0, out_r}, 32'h0);
    send(24'h000100, 24'hFFFF00, "R1");
    check("R1", "unity left", {8'h0, out_l}, 32'h000100);

    for (int i = 0; i < 9; i++) begin
      {in_l, in_r, code_l, code_r, indiv, mute, mono, mono_left} = VEC[i][79:12];
      for (int k = 0; k < int'(VEC[i][11:0]); k++)
        send(VEC[i][79:56], VEC[i][55:32], tag_of(i));
    end

    // R6: outputs hold and out_vld stays low between strobes
    hl = out_l; hr = out_r;
    repeat (3) @(negedge clk);
    check("R6", "hold", {out_l, out_vld}, {hl, 1'b0});
    check("R6", "hold r", {8'h0, out_r}, {8'h0, hr});

    // R8 R9: DC idle run on both paths, left all-zero upper, right all-one upper
    zd_en = 1'b1;
    for (int k = 0; k < 8200; k++) send(24'h00000A, 24'hFFFFF5, "R9");
    check("R9", "zero_l after run", {31'h0, zero_l}, 32'h1);
    check("R10", "forced out_l", {8'h0, out_l}, 32'h0);
    // R9: enable gates the flag at once
    zd_en = 1'b0;
    #1;
    check("R9", "flags gated", {29'h0, zero_l, zero_r, zero_both}, 32'h0);
    send(24'h00000A, 24'hFFFFF5, "R9");
    check("R9", "unforced out_l", {8'h0, out_l}, 32'h00000A);
    zd_en = 1'b1;
    #1;
    check("R9", "flags return", {29'h0, zero_l, zero_r, zero_both}, 32'h7);
    // R10 with R4: mute ramps underneath forced outputs
    mute = 1'b1;
    for (int k = 0; k < 300; k++) send(24'h00000A, 24'hFFFFF5, "R10");
    // R8: changed low nibble breaks the left run only
    send(24'h00000B, 24'hFFFFF5, "R8");
    check("R8", "zero_l cleared", {29'h0, zero_l, zero_r, zero_both}, 32'h2);
    for (int k = 0; k < 4; k++) send(24'h7FFFFB, 24'hFFFFF5, "R10");
    // R8: upper bits not idle clear the right run
    send(24'h7FFFFB, 24'h000015, "R8");
    check("R8", "zero_r cleared", {31'h0, zero_r}, 32'h0);
    mute = 1'b0;
    for (int k = 0; k < 20; k++) send(24'h7FFFFB, 24'h000015, "R4");
    finish_run();
  end
endmodule